// File: doc/BRIEF.md
# Lock-Bit Protection Controller for External Programming

This block keeps a two-bit lock field and judges every request that an external programmer makes against the non-volatile memories. The requests are: program flash, verify (read back) flash, write the configuration section, write the signature section, write the calibration section, write the lock bits, and chip erase. Each request is answered one clock later with a single allow/deny flag.

The lock field follows programming semantics. A lock write can only move bits from unprogrammed (1) to programmed (0). Only a chip erase brings the bits back to 1. The field is presented as a full byte: the two lock bits sit at positions 1 and 0, and the padding bits above them always read as 1.

The storage is a register model. A parameter chooses what it holds after reset. It can come up erased (both bits 1), or it can load a fixed retained value, which models a part that was locked before power-down. The programming link protocol and the flash array are outside this block.

Top module: `nvm_lock_guard`

## Requirements
- R1: With the default erased-reset option, the lock byte reads 0xFF after reset and rsp_valid is low.
- R2: Bits above the two lock bits in lock_byte (bits 7:2 at default width) always read as 1.
- R3: With lock bits 1:0 = 11 (open), program flash, verify flash, configuration write, lock write and chip erase are all allowed.
- R4: Signature writes (op 3) and calibration writes (op 4) are denied in every lock state.
- R5: With lock bit 1 = 1 and bit 0 = 0, program flash and configuration write are denied and verify flash is allowed.
- R6: With both lock bits 0, program flash, verify flash and configuration write are all denied.
- R7: Lock bits 1:0 = 01 (bit 1 = 0, bit 0 = 1) deny the same operations as 00.
- R8: A lock write (op 5) sets the lock to old AND wr_lock_val. Writing a 1 over a programmed 0 leaves that bit at 0.
- R9: Chip erase (op 6) is allowed in every lock state. The lock bits read 11 from the cycle after the request onward.
- R10: req_op codes are 0 program flash, 1 verify flash, 2 configuration write, 3 signature write, 4 calibration write, 5 lock write, 6 chip erase, and 7 reserved. Op 7 is always denied. rsp_valid and rsp_allow are registered, and they answer the request sampled at the previous clock edge. rsp_valid stays low in a cycle after no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Request code (see R10) |
| wr_lock_val | input | LOCK_W (2) | Value ANDed into the lock on a lock write |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_allow | output | 1 | 1 = request allowed, 0 = denied |
| lock_byte | output | DATA_W (8) | Padding of ones above the lock bits |

## Verification
The decision table is swept with every request code in each of the four lock states: 11, 10, 00, and the odd case 01. This separates the partial lock, where only verify survives, from the full lock. It also shows that 01 is not mistaken for open or for partial lock. Lock writes are issued with values that try to raise a bit that is already programmed. This exposes any plain-overwrite update, as opposed to an AND update. Chip erase is issued from a locked state to show that it is honoured there and that the lock byte returns to 0xFF one cycle later. Idle cycles and the reserved code check that rsp_valid is not stuck high and that no response is allowed by default.

// File: rtl/nvm_lock_pkg.sv
package nvm_lock_pkg;

   typedef enum logic [2:0] {
      OP_PROG_FLASH  = 3'd0,
      OP_VERIFY      = 3'd1,
      OP_WR_CONFIG   = 3'd2,
      OP_WR_SIG      = 3'd3,
      OP_WR_CAL      = 3'd4,
      OP_WR_LOCK     = 3'd5,
      OP_CHIP_ERASE  = 3'd6,
      OP_RESERVED    = 3'd7
   } prog_op_t;

   typedef enum logic [1:0] {
      MODE_OPEN   = 2'd0,
      MODE_NOPROG = 2'd1,
      MODE_FULL   = 2'd2
   } lock_mode_t;

   localparam int unsigned OP_W = 3;

endpackage

// File: rtl/nvm_lock_store.sv
module nvm_lock_store #(
   parameter int unsigned      LOCK_W        = 2,
   parameter bit               RESET_ERASED  = 1'b1,
   parameter logic [LOCK_W-1:0] RETAINED_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LOCK_W-1:0] wr_val,
   input  logic              erase,
   output logic [LOCK_W-1:0] lock_q
);

   logic [LOCK_W-1:0] rst_val;

   generate
      if (RESET_ERASED) begin : g_erased
         assign rst_val = {LOCK_W{1'b1}};
      end else begin : g_retained
         assign rst_val = RETAINED_INIT;
      end
   endgenerate

   generate
      for (genvar b = 0; b < LOCK_W; b++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lock_q[b] <= rst_val[b];
            end else if (erase) begin
               lock_q[b] <= 1'b1;
            end else if (wr_en) begin
               lock_q[b] <= lock_q[b] & wr_val[b];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/nvm_lock_mode_decode.sv
module nvm_lock_mode_decode
   import nvm_lock_pkg::*;
#(
   parameter int unsigned LOCK_W = 2
) (
   input  logic [LOCK_W-1:0] lock_bits,
   output lock_mode_t        mode
);

   always_comb begin
      if (lock_bits[1] == 1'b0) begin
         mode = MODE_FULL;
      end else if (lock_bits[0] == 1'b0) begin
         mode = MODE_NOPROG;
      end else begin
         mode = MODE_OPEN;
      end
   end

endmodule

// File: rtl/nvm_access_policy.sv
module nvm_access_policy
   import nvm_lock_pkg::*;
(
   input  lock_mode_t mode,
   input  prog_op_t   op,
   output logic       allow
);

   logic flash_write_ok;
   logic flash_read_ok;

   assign flash_write_ok = (mode == MODE_OPEN);
   assign flash_read_ok  = (mode != MODE_FULL);

   always_comb begin
      unique case (op)
         OP_PROG_FLASH: allow = flash_write_ok;
         OP_WR_CONFIG:  allow = flash_write_ok;
         OP_VERIFY:     allow = flash_read_ok;
         OP_WR_SIG:     allow = 1'b0;
         OP_WR_CAL:     allow = 1'b0;
         OP_WR_LOCK:    allow = 1'b1;
         OP_CHIP_ERASE: allow = 1'b1;
         default:       allow = 1'b0;
      endcase
   end

endmodule

// File: rtl/nvm_lock_guard.sv
module nvm_lock_guard
   import nvm_lock_pkg::*;
#(
   parameter int unsigned       LOCK_W        = 2,
   parameter int unsigned       DATA_W        = 8,
   parameter bit                RESET_ERASED  = 1'b1,
   parameter logic [LOCK_W-1:0] RETAINED_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [LOCK_W-1:0] wr_lock_val,
   output logic              rsp_valid,
   output logic              rsp_allow,
   output logic [DATA_W-1:0] lock_byte
);

   localparam int unsigned PAD_W = DATA_W - LOCK_W;

   initial begin
      assert (LOCK_W == 2)
         else $fatal(1, "nvm_lock_guard: LOCK_W must be 2");
      assert (DATA_W > LOCK_W)
         else $fatal(1, "nvm_lock_guard: DATA_W must exceed LOCK_W");
   end

   prog_op_t          op;
   lock_mode_t        mode;
   logic              allow_c;
   logic              lock_wr;
   logic              lock_erase;
   logic [LOCK_W-1:0] lock_q;

   assign op         = prog_op_t'(req_op);
   assign lock_wr    = req_valid && (op == OP_WR_LOCK);
   assign lock_erase = req_valid && (op == OP_CHIP_ERASE);

   nvm_lock_store #(
      .LOCK_W        (LOCK_W),
      .RESET_ERASED  (RESET_ERASED),
      .RETAINED_INIT (RETAINED_INIT)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (lock_wr),
      .wr_val (wr_lock_val),
      .erase  (lock_erase),
      .lock_q (lock_q)
   );

   nvm_lock_mode_decode #(
      .LOCK_W (LOCK_W)
   ) u_mode (
      .lock_bits (lock_q),
      .mode      (mode)
   );

   nvm_access_policy u_policy (
      .mode  (mode),
      .op    (op),
      .allow (allow_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_allow <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_allow <= req_valid && allow_c;
      end
   end

   assign lock_byte = {{PAD_W{1'b1}}, lock_q};

endmodule

// File: rtl/nvm_lock_guard_chk.sv
module nvm_lock_guard_chk #(
   parameter int unsigned LOCK_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_op,
   input logic              rsp_valid,
   input logic              rsp_allow,
   input logic [DATA_W-1:0] lock_byte
);

   localparam int unsigned PAD_W = DATA_W - LOCK_W;

   assert_upper_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lock_byte[DATA_W-1:LOCK_W] == {PAD_W{1'b1}});

   assert_sig_cal_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 3'd3 || req_op == 3'd4)) |=> (rsp_valid && !rsp_allow));

   assert_full_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !lock_byte[1] && req_op <= 3'd2) |=> !rsp_allow);

   assert_no_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op != 3'd6)
         |=> ((lock_byte[LOCK_W-1:0] & ~$past(lock_byte[LOCK_W-1:0])) == '0));

   assert_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd6) |=> (rsp_allow && lock_byte[LOCK_W-1:0] == '1));

   assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_allow));

endmodule

bind nvm_lock_guard nvm_lock_guard_chk #(
   .LOCK_W (LOCK_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .rsp_valid (rsp_valid),
   .rsp_allow (rsp_allow),
   .lock_byte (lock_byte)
);

// File: tb/nvm_lock_guard_tb.sv
module nvm_lock_guard_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_op = 3'd0;
   logic [1:0] wr_lock_val = 2'b11;
   logic       rsp_valid;
   logic       rsp_allow;
   logic [7:0] lock_byte;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   nvm_lock_guard u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_op      (req_op),
      .wr_lock_val (wr_lock_val),
      .rsp_valid   (rsp_valid),
      .rsp_allow   (rsp_allow),
      .lock_byte   (lock_byte)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Issue one request; sample response on the negedge after the capturing posedge.
   task automatic issue(input logic [2:0] op, input logic [1:0] val, output logic allow);
      @(negedge clk);
      req_valid   = 1'b1;
      req_op      = op;
      wr_lock_val = val;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 rsp_valid after request", {7'd0, rsp_valid}, 8'd1);
      allow = rsp_allow;
   endtask

   task automatic expect_op(string req, input logic [2:0] op, input logic exp);
      logic a;
      issue(op, 2'b11, a);
      check(req, {7'd0, a}, {7'd0, exp});
   endtask

   task automatic t_reset;
      check("R1 reset lock byte", lock_byte, 8'hFF);
      check("R1 reset rsp_valid", {7'd0, rsp_valid}, 8'd0);
      check("R2 padding ones at reset", {2'b00, lock_byte[7:2]}, 8'h3F);
   endtask

   task automatic t_open;
      expect_op("R3 open program", 3'd0, 1'b1);
      expect_op("R3 open verify", 3'd1, 1'b1);
      expect_op("R3 open config", 3'd2, 1'b1);
      expect_op("R4 open signature", 3'd3, 1'b0);
      expect_op("R4 open calibration", 3'd4, 1'b0);
      expect_op("R10 open reserved", 3'd7, 1'b0);
      check("R3 open ops keep lock", lock_byte, 8'hFF);
   endtask

   task automatic t_noprog;
      logic a;
      issue(3'd5, 2'b10, a);
      check("R3 lock write allowed", {7'd0, a}, 8'd1);
      check("R8 lock after write 10", lock_byte, 8'hFE);
      expect_op("R5 partial program", 3'd0, 1'b0);
      expect_op("R5 partial config", 3'd2, 1'b0);
      expect_op("R5 partial verify", 3'd1, 1'b1);
      expect_op("R4 partial signature", 3'd3, 1'b0);
      issue(3'd5, 2'b11, a);
      check("R8 raise attempt ignored", lock_byte, 8'hFE);
      check("R2 padding in partial", {2'b00, lock_byte[7:2]}, 8'h3F);
   endtask

   task automatic t_erase;
      logic a;
      issue(3'd6, 2'b00, a);
      check("R9 erase allowed", {7'd0, a}, 8'd1);
      check("R9 lock cleared to ones", lock_byte, 8'hFF);
   endtask

   task automatic t_mode01;
      logic a;
      issue(3'd5, 2'b01, a);
      check("R8 lock after write 01", lock_byte, 8'hFD);
      expect_op("R7 mode01 program", 3'd0, 1'b0);
      expect_op("R7 mode01 verify", 3'd1, 1'b0);
      expect_op("R7 mode01 config", 3'd2, 1'b0);
      expect_op("R7 mode01 erase", 3'd6, 1'b1);
      check("R9 erase from 01", lock_byte, 8'hFF);
   endtask

   task automatic t_full;
      logic a;
      issue(3'd5, 2'b10, a);
      issue(3'd5, 2'b01, a);
      check("R8 AND accumulates to 00", lock_byte, 8'hFC);
      expect_op("R6 full program", 3'd0, 1'b0);
      expect_op("R6 full verify", 3'd1, 1'b0);
      expect_op("R6 full config", 3'd2, 1'b0);
      expect_op("R4 full calibration", 3'd4, 1'b0);
      expect_op("R10 full reserved", 3'd7, 1'b0);
      check("R8 denied ops keep lock", lock_byte, 8'hFC);
      expect_op("R9 erase from full", 3'd6, 1'b1);
      check("R9 full erase clears", lock_byte, 8'hFF);
   endtask

   task automatic t_idle;
      @(negedge clk);
      @(negedge clk);
      check("R10 idle rsp_valid", {7'd0, rsp_valid}, 8'd0);
      check("R10 idle rsp_allow", {7'd0, rsp_allow}, 8'd0);
   endtask

   initial begin
      #(8 * 50000);
      bad++;
      total++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_open();
      t_noprog();
      t_erase();
      t_mode01();
      t_full();
      t_idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule